// File: doc/BRIEF.md
# Folded Booth-digit FIR filter

This block is a programmable finite impulse response filter that computes many taps with few arithmetic units. It runs them over several clock cycles per output sample. A small bank of multiply cells handles one group of taps at a time. Each cell multiplies a stored coefficient by one signed radix-4 digit of the matching delayed sample. The cells' partial products meet in a binary adder tree. The tree's sum, weighted by the digit position, is added into a running total. When every digit of every tap group has been processed, the total is the filtered output.

With the default parameters the filter has 128 taps, takes 10-bit two's-complement samples and coefficients, and uses 64 multiply cells. Each output takes 10 steps: 5 digit positions times 2 tap groups. A new sample may therefore enter every 10 clock cycles. Coefficients are loaded one at a time through an address/data write port while the filter is idle.

Top module: `folded_booth_fir`

## Requirements
- R1: After reset, out_valid and out_data are 0, and all stored samples and coefficients read as zero. A sample processed before any coefficient is written therefore yields out_data = 0.
- R2: For each accepted sample x[n], out_data equals sum over k = 0..NTAPS-1 of c[k]·x[n-k]. Here c[k] is the coefficient at address k, and samples older than reset count as 0. The result is the exact two's-complement value in DW+CW+log2(NTAPS) bits (27 by default).
- R3: A sample sampled with in_valid high at clock edge E is reported with out_valid high for exactly one cycle, the cycle after edge E+10 (default). out_data keeps its value until the next out_valid.
- R4: A sample presented on the last processing cycle of the previous one is accepted, so samples may arrive back to back every 10 cycles, each giving a correct output.
- R5: in_valid asserted while a sample is being processed, other than on its last cycle, is ignored. It does not disturb the current output, and the ignored value never enters the sample history.
- R6: A write with cf_we high while idle stores cf_data at tap address cf_addr. Address k weights the sample k positions older than the newest.
- R7: A coefficient write arriving while a sample is being processed is dropped, and the stored coefficient keeps its old value.
- R8: The most negative operands are exact. With every coefficient at -512 and the history full of -512, out_data = 128·262144 = 33554432.
- R9: Each sample is split into radix-4 digits from the overlapping bit triples (b[2i+1], b[2i], b[2i-1]) with b[-1] = 0. The triples 000..111 map to 0, +1, +1, +2, -2, -1, -1, 0, weighted 4^i. This is checked through R2 using samples whose bit patterns cover every triple.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_data | input | DW (10) | Sample, two's complement |
| cf_we | input | 1 | Coefficient write enable |
| cf_addr | input | log2(NTAPS) (7) | Coefficient tap address |
| cf_data | input | CW (10) | Coefficient, two's complement |
| out_valid | output | 1 | One-cycle strobe for a finished output |
| out_data | output | DW+CW+log2(NTAPS) (27) | Filtered sample, two's complement |

## Verification
A wrong digit decode, a wrong tap-group selection or a wrong digit weight corrupts out_data on the next output. That output arrives 10 cycles after acceptance. A fault in the sample history or the coefficient store may show up only when the affected tap meets a non-zero operand, so the bench sends long runs of varied samples against varied coefficients. A fault in the step counter moves the out_valid pulse, or makes the filter take or drop a strobe it should not. Either shows within one 10-cycle frame.

// File: rtl/fir_fold_pkg.sv
// Package: shared types and the radix-4 digit decoder for the folded FIR.
// Assumes: callers pass the bit triple {b[2i+1], b[2i], b[2i-1]}.
package fir_fold_pkg;

    typedef struct packed {
        logic neg;   // digit is negative
        logic one;   // magnitude 1
        logic two;   // magnitude 2
    } booth_dig_t;

    function automatic booth_dig_t booth_decode(input logic [2:0] trip);
        booth_dig_t d;
        d = '0;
        case (trip)
            3'b001, 3'b010: d.one = 1'b1;
            3'b011:         d.two = 1'b1;
            3'b100:         begin d.two = 1'b1; d.neg = 1'b1; end
            3'b101, 3'b110: begin d.one = 1'b1; d.neg = 1'b1; end
            default:        d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/fir_booth_pe.sv
// Module: one multiply cell; forms a coefficient times a radix-4 digit.
// Assumes: a negative digit is finished by the tree adding neg_cin once,
// so pp plus neg_cin is the exact product.
module fir_booth_pe
    import fir_fold_pkg::*;
#(
    parameter int CW = 10
) (
    input  booth_dig_t    dig,
    input  logic [CW-1:0] coef,
    output logic [CW:0]   pp,
    output logic          neg_cin
);

    logic [CW:0] mag;

    // select 0, c or 2c, then invert for negative digits
    always_comb begin
        if (dig.two)      mag = {coef, 1'b0};
        else if (dig.one) mag = {coef[CW-1], coef};
        else              mag = '0;
        pp      = dig.neg ? ~mag : mag;
        neg_cin = dig.neg;
    end

endmodule

// File: rtl/fir_adder_tree.sv
// Module: binary adder tree over N signed partial products.
// The negation carry bits of all leaves are counted and added once at the root.
// Assumes: N is a power of two and OW is wide enough for the full sum.
module fir_adder_tree #(
    parameter int N  = 64,
    parameter int IW = 11,
    parameter int OW = 18
) (
    input  logic [N-1:0][IW-1:0] leaf,
    input  logic [N-1:0]         cin,
    output logic [OW-1:0]        sum
);

    logic [OW-1:0] node [1:2*N-1];
    logic [OW-1:0] cin_cnt;

    for (genvar i = 0; i < N; i++) begin : g_leaf
        assign node[N+i] = {{(OW-IW){leaf[i][IW-1]}}, leaf[i]};
    end

    for (genvar k = 1; k < N; k++) begin : g_node
        assign node[k] = node[2*k] + node[2*k+1];
    end

    // single injection point for all carry-in bits
    always_comb begin
        cin_cnt = OW'($countones(cin));
        sum     = node[1] + cin_cnt;
    end

endmodule

// File: rtl/fir_fold_ctrl.sv
// Module: step sequencer; walks digit positions and tap groups for one sample.
// Assumes: a sample presented on the last step starts the next frame at once.
module fir_fold_ctrl #(
    parameter int NDIG = 5,
    parameter int NGRP = 2,
    localparam int DGW = (NDIG > 1) ? $clog2(NDIG) : 1,
    localparam int GGW = (NGRP > 1) ? $clog2(NGRP) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    output logic           busy,
    output logic           accept,
    output logic           last,
    output logic [DGW-1:0] dig,
    output logic [GGW-1:0] grp
);

    // decode acceptance and the final step
    always_comb begin
        last   = busy && (dig == DGW'(NDIG-1)) && (grp == GGW'(NGRP-1));
        accept = in_valid && (!busy || last);
    end

    // advance the group counter, then the digit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            dig  <= '0;
            grp  <= '0;
        end else if (accept) begin
            busy <= 1'b1;
            dig  <= '0;
            grp  <= '0;
        end else if (busy) begin
            if (last) begin
                busy <= 1'b0;
                dig  <= '0;
                grp  <= '0;
            end else if (grp == GGW'(NGRP-1)) begin
                grp <= '0;
                dig <= dig + 1'b1;
            end else begin
                grp <= grp + 1'b1;
            end
        end
    end

endmodule

// File: rtl/folded_booth_fir.sv
// Module: top of the folded radix-4 digit FIR filter.
// Holds the sample history and the coefficient store and feeds NTAPS/NGRP
// multiply cells one digit per step. Each tree sum is weighted by 4^digit
// and accumulated.
// Assumes: DW is even, NTAPS/NGRP is a power of two, and coefficient writes
// occur while idle (others are dropped).
module folded_booth_fir
    import fir_fold_pkg::*;
#(
    parameter int DW    = 10,
    parameter int CW    = 10,
    parameter int NTAPS = 128,
    parameter int NGRP  = 2,
    localparam int AW   = $clog2(NTAPS),
    localparam int OW   = DW + CW + AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic          cf_we,
    input  logic [AW-1:0] cf_addr,
    input  logic [CW-1:0] cf_data,
    output logic          out_valid,
    output logic [OW-1:0] out_data
);

    localparam int NPE  = NTAPS / NGRP;
    localparam int NDIG = DW / 2;
    localparam int PPW  = CW + 1;
    localparam int TW   = PPW + $clog2(NPE) + 1;
    localparam int DGW  = (NDIG > 1) ? $clog2(NDIG) : 1;
    localparam int GGW  = (NGRP > 1) ? $clog2(NGRP) : 1;

    logic           busy, accept, last;
    logic [DGW-1:0] dig;
    logic [GGW-1:0] grp;

    logic [DW-1:0] smp [NTAPS];
    logic [CW-1:0] cof [NTAPS];

    logic [NPE-1:0][PPW-1:0] pp_all;
    logic [NPE-1:0]          cin_all;
    logic [TW-1:0]           tree_sum;
    logic [OW-1:0]           tree_ext, weighted, acc, acc_next;

    fir_fold_ctrl #(.NDIG(NDIG), .NGRP(NGRP)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .busy     (busy),
        .accept   (accept),
        .last     (last),
        .dig      (dig),
        .grp      (grp)
    );

    // sample history: newest at index 0, shifted on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NTAPS; k++) smp[k] <= '0;
        end else if (accept) begin
            smp[0] <= in_data;
            for (int k = 1; k < NTAPS; k++) smp[k] <= smp[k-1];
        end
    end

    // coefficient store: written only while no sample is in flight
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NTAPS; k++) cof[k] <= '0;
        end else if (cf_we && !busy) begin
            cof[cf_addr] <= cf_data;
        end
    end

    for (genvar j = 0; j < NPE; j++) begin : g_pe
        logic [AW-1:0] tap;
        logic [DW:0]   ext;
        logic [2:0]    trip;
        booth_dig_t    dcode;

        // pick this cell's tap in the current group and its digit triple
        always_comb begin
            tap   = AW'(int'(grp) * NPE + j);
            ext   = {smp[tap], 1'b0};
            trip  = ext[{dig, 1'b0} +: 3];
            dcode = booth_decode(trip);
        end

        fir_booth_pe #(.CW(CW)) u_pe (
            .dig     (dcode),
            .coef    (cof[tap]),
            .pp      (pp_all[j]),
            .neg_cin (cin_all[j])
        );
    end

    fir_adder_tree #(.N(NPE), .IW(PPW), .OW(TW)) u_tree (
        .leaf (pp_all),
        .cin  (cin_all),
        .sum  (tree_sum)
    );

    // weight the tree sum by 4^digit and add it to the running total
    always_comb begin
        tree_ext = {{(OW-TW){tree_sum[TW-1]}}, tree_sum};
        weighted = tree_ext << {dig, 1'b0};
        acc_next = acc + weighted;
    end

    // running total: cleared on a new sample, updated on every step
    always_ff @(posedge clk) begin
        if (!rst_n)      acc <= '0;
        else if (accept) acc <= '0;
        else if (busy)   acc <= acc_next;
    end

    // result register and one-cycle strobe on the final step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= last;
            if (last) out_data <= acc_next;
        end
    end

endmodule

// File: rtl/fir_fold_chk.sv
// Module: protocol checker for folded_booth_fir, attached by bind.
// Counts steps since the last accepted sample, so it does not rely on the
// sequencer's own step counters.
module fir_fold_chk #(
    parameter int NSTEP = 10,
    parameter int OW    = 27
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          accept,
    input logic          busy,
    input logic          out_valid,
    input logic [OW-1:0] out_data
);

    logic [7:0] cnt;

    // steps elapsed since the most recent acceptance
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (accept) cnt <= '0;
        else if (busy)   cnt <= cnt + 1'b1;
    end

    AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> ($past(cnt) == 8'(NSTEP-1))); // R3
    AST_OUT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) out_valid |=> !out_valid); // R3
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !out_valid |-> $stable(out_data)); // R3
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) accept |=> busy); // R4
    AST_IGNORE_MIDRUN: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && busy && cnt != 8'(NSTEP-1)) |=> (cnt == $past(cnt) + 8'd1)); // R5
    AST_OUT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> !$isunknown(out_data)); // R2

endmodule

bind folded_booth_fir fir_fold_chk #(.NSTEP(NDIG*NGRP), .OW(OW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .accept    (accept),
    .busy      (busy),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/folded_booth_fir_bench.sv
module folded_booth_fir_bench;

    localparam int DW = 10, CW = 10, NTAPS = 128, AW = 7, OW = 27;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          cf_we = 1'b0;
    logic [AW-1:0] cf_addr = '0;
    logic [CW-1:0] cf_data = '0;
    logic          out_valid;
    logic [OW-1:0] out_data;

    folded_booth_fir u_folded_booth_fir (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .cf_we(cf_we), .cf_addr(cf_addr), .cf_data(cf_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    always #5 clk = ~clk;

    // samples covering every digit triple, the extremes and sign changes
    localparam int NVEC = 20;
    localparam int SMP_TBL [NVEC] = '{
        1, -1, 511, -512, 341, -342, 0, 2, -2, 170,
        -171, 255, -256, 85, 100, -300, 3, -4, 449, -77
    };

    int     n_chk = 0, n_fail = 0;
    int     hist [NTAPS];
    int     cm   [NTAPS];
    bit     pend = 0;
    logic [OW-1:0] pexp;
    string  ptag;
    bit     early = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [OW-1:0] model();
        longint s = 0;
        for (int k = 0; k < NTAPS; k++) s += longint'(cm[k]) * longint'(hist[k]);
        return OW'(s);
    endfunction

    task automatic wr_coef(input int a, input int v);
        cf_we = 1'b1; cf_addr = AW'(a); cf_data = CW'(v);
        @(negedge clk);
        cf_we = 1'b0;
        cm[a] = v;
    endtask

    // check a pending output visible at this negedge
    task automatic take_pending();
        if (pend) begin
            chk(out_valid === 1'b1 && out_data === pexp, ptag,
                longint'($signed(out_data)), longint'($signed(pexp)));
            pend = 0;
        end
    endtask

    // drive a sample now; returns at the negedge before its last step ends
    task automatic send(input int x, input string tag, input bit inj, input bit cwr, input int cwv);
        in_valid = 1'b1; in_data = DW'(x);
        @(negedge clk);
        in_valid = 1'b0;
        take_pending();
        for (int k = NTAPS-1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = x;
        pexp = model(); ptag = tag; pend = 1;
        for (int i = 1; i <= 9; i++) begin
            @(negedge clk);
            if (out_valid) early = 1;
            if (i == 3 && inj) begin in_valid = 1'b1; in_data = DW'(-200); end
            if (i == 3 && cwr) begin cf_we = 1'b1; cf_addr = '0; cf_data = CW'(cwv); end
            if (i == 4) begin in_valid = 1'b0; cf_we = 1'b0; end
        end
    endtask

    task automatic flush();
        @(negedge clk);
        take_pending();
        @(negedge clk);
        chk(out_valid === 1'b0, "R3 strobe one cycle", longint'(out_valid), 0);
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int k = 0; k < NTAPS; k++) begin hist[k] = 0; cm[k] = 0; end
        repeat (3) @(negedge clk);
        chk(out_valid === 1'b0, "R1 reset out_valid", longint'(out_valid), 0);
        chk(out_data === '0, "R1 reset out_data", longint'(out_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid === 1'b0 && out_data === '0, "R1 idle after reset", longint'(out_data), 0);

        // R1: zero coefficients give zero output
        send(37, "R1 zero coefficients", 0, 0, 0);
        flush();

        // R6: load varied coefficients while idle
        for (int k = 0; k < NTAPS; k++) wr_coef(k, ((k * 37 + 11) % 1024) - 512);
        wr_coef(5, -512);
        wr_coef(127, 511);

        // R2, R4, R9: table walked back to back
        for (int v = 0; v < NVEC; v++) send(SMP_TBL[v], "R2 R4 R9 table output", 0, 0, 0);
        flush();
        chk(early == 0, "R3 no early strobe", longint'(early), 0);

        // R5: mid-run strobe ignored
        send(123, "R5 output under stray strobe", 1, 0, 0);
        send(-45, "R5 history excludes stray value", 0, 0, 0);
        flush();

        // R7: write while busy dropped
        send(222, "R7 output during dropped write", 0, 1, 300);
        send(-333, "R7 coefficient unchanged", 0, 0, 0);
        flush();

        // R6: write while idle takes effect on tap 0
        wr_coef(0, 300);
        send(7, "R6 idle write applied", 0, 0, 0);
        flush();

        // R8: most negative operands everywhere
        for (int k = 0; k < NTAPS; k++) wr_coef(k, -512);
        for (int k = 0; k < NTAPS; k++) send(-512, "R8 extreme operands", 0, 0, 0);
        flush();
        chk(out_data === OW'(33554432), "R8 full extreme sum",
            longint'($signed(out_data)), 33554432);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule